// File: doc/BRIEF.md
# Interrupt Status Aggregator with Set/Clear Enable Mask

This block collects completion events from a serial flash engine into a raw status register. It qualifies them with an enable mask and drives one level-sensitive interrupt line. The main event is the word-transfer-complete pulse, which sits at bit 1. The number of event bits is a parameter, and event bit `i` maps to status bit `i`.

Software reaches four word registers through a simple strobe bus. The raw view shows every captured event, and writing ones to it forces bits, which is useful for test. The masked view shows raw AND mask, and writing ones to it acknowledges (clears) raw bits. The mask is never written directly: one register sets mask bits and another clears them, and both read back the current mask. An interrupt handler that reads zero from the masked view knows the interrupt was spurious.

Reads return their data one cycle after the read strobe. The interrupt line follows the registered state, so it changes in the cycle after the edge that alters the raw bits or the mask.

Top module: `irq_status_unit`

## Requirements
- R1: A synchronous active-high reset clears all raw bits and all mask bits. After reset the interrupt line is low and every register reads 0.
- R2: A high on `evt_i[i]` at a clock edge sets raw bit `i`. The word-complete event is bit 1. The raw view at offset 0x20 shows the bit whatever the mask holds.
- R3: Writing to offset 0x20 sets every raw bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: Writing to offset 0x28 sets every mask bit whose write-data bit is 1. Bits written 0 keep their value. The mask reads back at both 0x28 and 0x2C.
- R5: Writing to offset 0x2C clears every mask bit whose write-data bit is 1. Bits written 0 keep their value.
- R6: A read of offset 0x24 returns raw AND mask. It is 0 when no enabled bit is pending, even if raw bits are set.
- R7: Writing to offset 0x24 clears every raw bit whose write-data bit is 1, whether or not that bit is enabled. Bits written 0 keep their value.
- R8: If an event on bit `i` arrives at the same edge as a write that clears raw bit `i`, the bit stays set.
- R9: `irq_o` is high exactly when some raw bit and its mask bit are both set. It reflects the state registered at the most recent edge.
- R10: Read data appears on `rdata_o` one cycle after `rd_i` and holds until the next read. Unmapped offsets read 0. Bits at or above NUM_IRQ read 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_i` |
| evt_i | input | NUM_IRQ | Event pulses from the serial engine, bit 1 is word complete |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with NUM_IRQ = 4, DATA_W = 32 and ADDR_W = 8. With four bits, the acknowledge, force and mask operations can be shown to touch only the bits written as 1 while neighbouring bits keep their value. Writing all ones into the raw view shows that bits above the implemented width read back as 0. The 8-bit address also reaches an unmapped offset and an offset that is not word-aligned. A cycle where an event and an acknowledge land on the same edge is driven, and a mid-run reset checks that reset clears the raw bits and the mask.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    // Word offsets of the four registers
    localparam int unsigned OFF_RAW   = 32'h20;
    localparam int unsigned OFF_MASKD = 32'h24;
    localparam int unsigned OFF_ENSET = 32'h28;
    localparam int unsigned OFF_ENCLR = 32'h2C;

    // Bit position of the word-complete event
    localparam int unsigned WC_BIT = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_MASKD,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

    typedef struct packed {
        logic raw_set;
        logic raw_clr;
        logic en_set;
        logic en_clr;
    } wr_cmd_t;

    function automatic reg_sel_e decode_sel(input int unsigned a);
        case (a)
            OFF_RAW:   return SEL_RAW;
            OFF_MASKD: return SEL_MASKD;
            OFF_ENSET: return SEL_ENSET;
            OFF_ENCLR: return SEL_ENCLR;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irqs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_sel_e          sel_o,
    output wr_cmd_t           cmd_o
);
    always_comb begin
        sel_o = decode_sel(int'(unsigned'(addr_i)));
        cmd_o = '0;
        if (wr_i) begin
            cmd_o.raw_set = (sel_o == SEL_RAW);
            cmd_o.raw_clr = (sel_o == SEL_MASKD);
            cmd_o.en_set  = (sel_o == SEL_ENSET);
            cmd_o.en_clr  = (sel_o == SEL_ENCLR);
        end
    end
endmodule

// File: rtl/irq_bit.sv
module irq_bit
    import irqs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd_i,
    input  logic    wbit_i,
    input  logic    evt_i,
    output logic    raw_o,
    output logic    en_o
);
    logic raw_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            // event has priority over an acknowledge in the same cycle
            if (evt_i || (cmd_i.raw_set && wbit_i))
                raw_q <= 1'b1;
            else if (cmd_i.raw_clr && wbit_i)
                raw_q <= 1'b0;
            if (cmd_i.en_set && wbit_i)
                en_q <= 1'b1;
            else if (cmd_i.en_clr && wbit_i)
                en_q <= 1'b0;
        end
    end

    assign raw_o = raw_q;
    assign en_o  = en_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!raw_q && !en_q));
    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst) evt_i |=> raw_q);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.raw_clr && wbit_i && !evt_i) |=> !raw_q);
    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.en_set && wbit_i) |=> en_q);
    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.en_clr && wbit_i) |=> !en_q);
    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wbit_i || !(cmd_i.en_set || cmd_i.en_clr)) |=> $stable(en_q));
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
    import irqs_pkg::*;
#(
    parameter int NUM_IRQ = 2,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_i,
    input  reg_sel_e           sel_i,
    input  logic [NUM_IRQ-1:0] raw_i,
    input  logic [NUM_IRQ-1:0] en_i,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [NUM_IRQ-1:0] pick;
    logic [DATA_W-1:0]  rdata_q;

    always_comb begin
        unique case (sel_i)
            SEL_RAW:              pick = raw_i;
            SEL_MASKD:            pick = raw_i & en_i;
            SEL_ENSET, SEL_ENCLR: pick = en_i;
            default:              pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_i)
            rdata_q <= DATA_W'(pick);
    end

    assign rdata_o = rdata_q;

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irqs_pkg::*;
#(
    parameter int NUM_IRQ = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               rd_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_IRQ-1:0] evt_i,
    output logic               irq_o
);
    localparam int MASKD_ADDR = int'(OFF_MASKD);

    reg_sel_e           sel;
    wr_cmd_t            cmd;
    logic [NUM_IRQ-1:0] raw, en;

    irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .wr_i   (wr_i),
        .sel_o  (sel),
        .cmd_o  (cmd)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        irq_bit u_bit (
            .clk    (clk),
            .rst    (rst),
            .cmd_i  (cmd),
            .wbit_i (wdata_i[i]),
            .evt_i  (evt_i[i]),
            .raw_o  (raw[i]),
            .en_o   (en[i])
        );
    end

    irq_rdmux #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_i    (rd_i),
        .sel_i   (sel),
        .raw_i   (raw),
        .en_i    (en),
        .rdata_o (rdata_o)
    );

    assign irq_o = |(raw & en);

    // R6
    spurious_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == ADDR_W'(MASKD_ADDR) && !irq_o) |=> (rdata_o == '0));
    // R9
    irq_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == ADDR_W'(MASKD_ADDR) && irq_o) |=> (rdata_o != '0));
endmodule

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
    localparam int NI = 4;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 0;
    logic          rst = 1;
    logic [AW-1:0] addr = '0;
    logic          wr = 0;
    logic [DW-1:0] wdata = '0;
    logic          rd = 0;
    logic [DW-1:0] rdata;
    logic [NI-1:0] evt = '0;
    logic          irq;

    int compared = 0;
    int mismatched = 0;
    logic done = 0;
    logic rd_seen = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    irq_status_unit #(.NUM_IRQ(NI), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
        .rd_i(rd), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
    );

    always @(posedge clk) rd_seen <= rd && !rst;

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (rdata !== e) begin
                mismatched++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd = 1;
        @(negedge clk);
        rd = 0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NI-1:0] ev);
        @(negedge clk);
        addr = a; wdata = d; wr = 1; evt = ev;
        @(negedge clk);
        wr = 0; evt = '0;
    endtask

    task automatic pulse_evt(input logic [NI-1:0] ev);
        @(negedge clk);
        evt = ev;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        compared++;
        if (irq !== e) begin
            mismatched++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk_irq(1'b0, "R1 reset");
        do_read(8'h20, 32'h0, "R1 raw after reset");
        do_read(8'h28, 32'h0, "R1 mask after reset");
        do_read(8'h24, 32'h0, "R1 masked after reset");

        pulse_evt(4'b0010);
        chk_irq(1'b0, "R9 event masked");
        do_read(8'h20, 32'h2, "R2 raw word complete");
        do_read(8'h24, 32'h0, "R6 masked zero when disabled");

        do_write(8'h28, 32'h0, '0);
        do_read(8'h28, 32'h0, "R4 zero write ignored");
        do_write(8'h28, 32'h2, '0);
        chk_irq(1'b1, "R9 enable raises irq");
        do_read(8'h2C, 32'h2, "R4 mask readback at clear offset");
        do_read(8'h24, 32'h2, "R6 masked view");

        do_write(8'h24, 32'h0, '0);
        do_read(8'h20, 32'h2, "R7 zero ack ignored");
        do_write(8'h24, 32'h2, '0);
        chk_irq(1'b0, "R9 ack drops irq");
        do_read(8'h20, 32'h0, "R7 ack clears raw");

        do_write(8'h20, 32'hFFFF_FFF5, '0);
        do_read(8'h20, 32'h5, "R3 force raw, R10 upper bits zero");
        chk_irq(1'b0, "R9 forced bits not enabled");
        do_write(8'h28, 32'h1, '0);
        chk_irq(1'b1, "R9 forced bit enabled");
        do_read(8'h24, 32'h1, "R6 masked with two enables");

        do_write(8'h2C, 32'h0, '0);
        do_read(8'h28, 32'h3, "R5 zero clear ignored");
        do_write(8'h2C, 32'h1, '0);
        chk_irq(1'b0, "R5 disable drops irq");
        do_read(8'h24, 32'h0, "R6 spurious read zero");

        do_write(8'h24, 32'h3, 4'b0010);
        do_read(8'h20, 32'h6, "R8 event beats ack, bit0 cleared");
        chk_irq(1'b1, "R8 irq stays");

        do_read(8'h30, 32'h0, "R10 unmapped read");
        do_read(8'h22, 32'h0, "R10 unaligned read");
        do_write(8'h30, 32'hF, '0);
        do_read(8'h28, 32'h2, "R10 unmapped write ignored");
        do_read(8'h20, 32'h6, "R10 unmapped write raw unchanged");

        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk_irq(1'b0, "R1 mid-run reset irq");
        do_read(8'h20, 32'h0, "R1 mid-run reset raw");
        do_read(8'h2C, 32'h0, "R1 mid-run reset mask");

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule